// File: doc/BRIEF.md
# Grouped Interrupt Request Aggregator

This block merges a set of peripheral interrupt sources into a few shared group interrupts. Each group has one request flag and one vector. Every source has its own request flag and enable bit. A source flag is raised by a one-cycle event pulse from its peripheral, for example a timer's period-compare match, a timer's A-compare match, or the end of a memory write cycle. The flag stays raised until software clears it. A group flag rises while any enabled source flag in that group is raised.

The block offers a vector to the CPU when four conditions hold: a group flag is raised, that group is enabled, the global enable is set, and the call stack is not full. If several groups qualify, the lowest-numbered group wins. When the CPU acknowledges the vector, the block clears that group's flag and the global enable. It leaves the source flags alone, so software must clear them. Software can clear or set every flag, write the enables, and set the global enable again when it returns from the handler.

Source i belongs to group i / SRC_PER_GRP. With the defaults there are four groups of two sources each.

Top module: `grp_irq_agg`

## Requirements
- R1: After reset, all source flags, source enables, group flags and group enables are 0, the global enable is 0, and vec_req is 0.
- R2: A pulse on src_evt[i] or src_flag_set[i] sets src_flag[i] at the next clock edge. The flag stays set until a src_flag_clr[i] pulse clears it.
- R3: If a set pulse and src_flag_clr[i] arrive in the same cycle, src_flag[i] is 1 afterwards.
- R4: grp_flag[g] becomes 1 one clock edge after any source of group g has both its flag and its enable set. A source whose enable is 0 never sets its group flag.
- R5: vec_req is 1 exactly when some group has grp_flag and grp_en both 1, gie is 1 and stack_full is 0.
- R6: While vec_req is 1, vec_idx is the lowest index g for which grp_flag[g] and grp_en[g] are both 1.
- R7: An acknowledge cycle is one with vec_ack and vec_req both 1. At the next edge it clears grp_flag[vec_idx] and gie, so vec_req is 0 in the following cycle. This automatic clear takes priority over every software set in that cycle.
- R8: An acknowledge leaves every source flag unchanged.
- R9: If a serviced group still has a source flag and enable set, its group flag rises again one edge after the acknowledge. Writing gie_set then raises vec_req for that group again.
- R10: grp_flag_set[g] sets the group flag and grp_flag_clr[g] clears it. A set pulse, or a source condition from R4, wins over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | NUM_GROUPS*SRC_PER_GRP | One-cycle request pulses from the peripherals |
| src_flag_set | input | NUM_GROUPS*SRC_PER_GRP | Software set of source flags |
| src_flag_clr | input | NUM_GROUPS*SRC_PER_GRP | Software clear of source flags |
| src_en_we | input | 1 | Write strobe for source enables |
| src_en_wdata | input | NUM_GROUPS*SRC_PER_GRP | New source enable value |
| grp_flag_set | input | NUM_GROUPS | Software set of group flags |
| grp_flag_clr | input | NUM_GROUPS | Software clear of group flags |
| grp_en_we | input | 1 | Write strobe for group enables |
| grp_en_wdata | input | NUM_GROUPS | New group enable value |
| gie_set | input | 1 | Sets the global enable |
| gie_clr | input | 1 | Clears the global enable |
| stack_full | input | 1 | CPU call stack is full |
| vec_ack | input | 1 | CPU takes the offered vector |
| src_flag | output | NUM_GROUPS*SRC_PER_GRP | Source request flags |
| src_en | output | NUM_GROUPS*SRC_PER_GRP | Source enables |
| grp_flag | output | NUM_GROUPS | Group request flags |
| grp_en | output | NUM_GROUPS | Group enables |
| gie | output | 1 | Global interrupt enable |
| vec_req | output | 1 | Vector request level |
| vec_idx | output | IDX_W | Index of the requested group vector |

## Verification
The bench pulses each source in turn, first with all enables off and then with all enables on. This separates a source that is flagged from a source that reaches its group, and it checks the source-to-group mapping. A sweep over every combination of group flag, group enable and stack-full confirms the gating and the lowest-index priority. Acknowledge sequences with source flags left set separate the automatic group clear from the source flags that persist, and they show the group flag re-rising until software sets the global enable again. Same-cycle set and clear pulses check which one takes precedence.

// File: rtl/grp_irq_pkg.sv
package grp_irq_pkg;
  localparam int unsigned DEF_GROUPS  = 4;
  localparam int unsigned DEF_SRC_PER = 2;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/grp_irq_src_bank.sv
module grp_irq_src_bank #(
  parameter int unsigned NUM_GROUPS  = 4,
  parameter int unsigned SRC_PER_GRP = 2,
  localparam int unsigned NSRC = NUM_GROUPS * SRC_PER_GRP
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC-1:0]       evt,
  input  logic [NSRC-1:0]       sw_set,
  input  logic [NSRC-1:0]       sw_clr,
  input  logic                  en_we,
  input  logic [NSRC-1:0]       en_wdata,
  output logic [NSRC-1:0]       flag_q,
  output logic [NSRC-1:0]       en_q,
  output logic [NUM_GROUPS-1:0] grp_hit
);
  logic [NSRC-1:0] flag_d;
  logic [NSRC-1:0] en_d;

  // set pulses take precedence over a software clear
  always_comb begin
    flag_d = (flag_q & ~sw_clr) | evt | sw_set;
    en_d   = en_we ? en_wdata : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      flag_q <= flag_d;
      en_q   <= en_d;
    end
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_hit
    assign grp_hit[g] = |(flag_q[g*SRC_PER_GRP +: SRC_PER_GRP] &
                          en_q[g*SRC_PER_GRP +: SRC_PER_GRP]);
  end
endmodule

// File: rtl/grp_irq_grp_bank.sv
module grp_irq_grp_bank #(
  parameter int unsigned NUM_GROUPS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_GROUPS-1:0] hit,
  input  logic [NUM_GROUPS-1:0] sw_set,
  input  logic [NUM_GROUPS-1:0] sw_clr,
  input  logic                  en_we,
  input  logic [NUM_GROUPS-1:0] en_wdata,
  input  logic                  gie_set,
  input  logic                  gie_clr,
  input  logic                  ack_fire,
  input  logic [NUM_GROUPS-1:0] ack_clr,
  output logic [NUM_GROUPS-1:0] flag_q,
  output logic [NUM_GROUPS-1:0] en_q,
  output logic                  gie_q
);
  logic [NUM_GROUPS-1:0] flag_d;
  logic [NUM_GROUPS-1:0] en_d;
  logic                  gie_d;

  always_comb begin
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (ack_clr[g])                 flag_d[g] = 1'b0;
      else if (hit[g] || sw_set[g])   flag_d[g] = 1'b1;
      else if (sw_clr[g])             flag_d[g] = 1'b0;
      else                            flag_d[g] = flag_q[g];
    end
    en_d = en_we ? en_wdata : en_q;
    if (ack_fire)     gie_d = 1'b0;
    else if (gie_set) gie_d = 1'b1;
    else if (gie_clr) gie_d = 1'b0;
    else              gie_d = gie_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
      gie_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      en_q   <= en_d;
      gie_q  <= gie_d;
    end
  end
endmodule

// File: rtl/grp_irq_prio.sv
module grp_irq_prio #(
  parameter int unsigned NUM_GROUPS = 4,
  localparam int unsigned IDX_W = grp_irq_pkg::idx_width(NUM_GROUPS)
) (
  input  logic [NUM_GROUPS-1:0] elig,
  output logic                  req,
  output logic [IDX_W-1:0]      idx
);
  // scan from the top so the lowest eligible index is kept last
  always_comb begin
    idx = '0;
    for (int i = NUM_GROUPS - 1; i >= 0; i--) begin
      if (elig[i]) idx = IDX_W'(i);
    end
    req = |elig;
  end
endmodule

// File: rtl/grp_irq_agg.sv
module grp_irq_agg #(
  parameter int unsigned NUM_GROUPS  = grp_irq_pkg::DEF_GROUPS,
  parameter int unsigned SRC_PER_GRP = grp_irq_pkg::DEF_SRC_PER,
  localparam int unsigned NSRC  = NUM_GROUPS * SRC_PER_GRP,
  localparam int unsigned IDX_W = grp_irq_pkg::idx_width(NUM_GROUPS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC-1:0]       src_evt,
  input  logic [NSRC-1:0]       src_flag_set,
  input  logic [NSRC-1:0]       src_flag_clr,
  input  logic                  src_en_we,
  input  logic [NSRC-1:0]       src_en_wdata,
  input  logic [NUM_GROUPS-1:0] grp_flag_set,
  input  logic [NUM_GROUPS-1:0] grp_flag_clr,
  input  logic                  grp_en_we,
  input  logic [NUM_GROUPS-1:0] grp_en_wdata,
  input  logic                  gie_set,
  input  logic                  gie_clr,
  input  logic                  stack_full,
  input  logic                  vec_ack,
  output logic [NSRC-1:0]       src_flag,
  output logic [NSRC-1:0]       src_en,
  output logic [NUM_GROUPS-1:0] grp_flag,
  output logic [NUM_GROUPS-1:0] grp_en,
  output logic                  gie,
  output logic                  vec_req,
  output logic [IDX_W-1:0]      vec_idx
);
  logic [NUM_GROUPS-1:0] hit;
  logic [NUM_GROUPS-1:0] elig;
  logic [NUM_GROUPS-1:0] ack_clr;
  logic                  ack_fire;

  grp_irq_src_bank #(.NUM_GROUPS(NUM_GROUPS), .SRC_PER_GRP(SRC_PER_GRP)) u_src (
    .clk(clk), .rst_n(rst_n), .evt(src_evt), .sw_set(src_flag_set),
    .sw_clr(src_flag_clr), .en_we(src_en_we), .en_wdata(src_en_wdata),
    .flag_q(src_flag), .en_q(src_en), .grp_hit(hit)
  );

  grp_irq_grp_bank #(.NUM_GROUPS(NUM_GROUPS)) u_grp (
    .clk(clk), .rst_n(rst_n), .hit(hit), .sw_set(grp_flag_set),
    .sw_clr(grp_flag_clr), .en_we(grp_en_we), .en_wdata(grp_en_wdata),
    .gie_set(gie_set), .gie_clr(gie_clr), .ack_fire(ack_fire),
    .ack_clr(ack_clr), .flag_q(grp_flag), .en_q(grp_en), .gie_q(gie)
  );

  assign elig = grp_flag & grp_en & {NUM_GROUPS{gie & ~stack_full}};

  grp_irq_prio #(.NUM_GROUPS(NUM_GROUPS)) u_prio (
    .elig(elig), .req(vec_req), .idx(vec_idx)
  );

  assign ack_fire = vec_ack & vec_req;
  assign ack_clr  = ack_fire ? (NUM_GROUPS'(1) << vec_idx) : '0;
endmodule

// File: rtl/grp_irq_agg_chk.sv
module grp_irq_agg_chk #(
  parameter int unsigned NUM_GROUPS  = 4,
  parameter int unsigned SRC_PER_GRP = 2,
  localparam int unsigned NSRC  = NUM_GROUPS * SRC_PER_GRP,
  localparam int unsigned IDX_W = grp_irq_pkg::idx_width(NUM_GROUPS)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NSRC-1:0]       src_evt,
  input logic [NSRC-1:0]       src_flag_clr,
  input logic [NSRC-1:0]       src_flag,
  input logic [NSRC-1:0]       src_en,
  input logic [NUM_GROUPS-1:0] grp_flag,
  input logic [NUM_GROUPS-1:0] grp_en,
  input logic                  gie,
  input logic                  stack_full,
  input logic                  vec_ack,
  input logic                  vec_req,
  input logic [IDX_W-1:0]      vec_idx
);
  logic [NUM_GROUPS-1:0] live;
  logic [NUM_GROUPS-1:0] below;
  logic [NUM_GROUPS-1:0] served;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_live
    assign live[g] = |(src_flag[g*SRC_PER_GRP +: SRC_PER_GRP] &
                       src_en[g*SRC_PER_GRP +: SRC_PER_GRP]);
  end
  assign below  = (NUM_GROUPS'(1) << vec_idx) - NUM_GROUPS'(1);
  assign served = (vec_ack && vec_req) ? (NUM_GROUPS'(1) << vec_idx) : '0;

  a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_evt) |=> (($past(src_evt) & ~src_flag) == '0));

  a_r4_group_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (|live) |=> (($past(live) & ~$past(served) & ~grp_flag) == '0));

  a_r5_gating: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> (gie && !stack_full && grp_flag[vec_idx] && grp_en[vec_idx]));

  a_r6_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> ((grp_flag & grp_en & below) == '0));

  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ack && vec_req) |=> (!gie && !vec_req && !grp_flag[$past(vec_idx)]));

  a_r8_src_persist: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ack && vec_req) |=> ((($past(src_flag) & ~$past(src_flag_clr)) & ~src_flag) == '0));
endmodule

bind grp_irq_agg grp_irq_agg_chk #(.NUM_GROUPS(NUM_GROUPS), .SRC_PER_GRP(SRC_PER_GRP)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .src_flag_clr(src_flag_clr),
  .src_flag(src_flag), .src_en(src_en), .grp_flag(grp_flag), .grp_en(grp_en),
  .gie(gie), .stack_full(stack_full), .vec_ack(vec_ack), .vec_req(vec_req),
  .vec_idx(vec_idx)
);

// File: tb/test_grp_irq_agg.sv
module test_grp_irq_agg;
  localparam int G = 4;
  localparam int S = 2;
  localparam int N = G * S;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] src_evt, src_flag_set, src_flag_clr, src_en_wdata;
  logic         src_en_we;
  logic [G-1:0] grp_flag_set, grp_flag_clr, grp_en_wdata;
  logic         grp_en_we, gie_set, gie_clr, stack_full, vec_ack;
  logic [N-1:0] src_flag, src_en;
  logic [G-1:0] grp_flag, grp_en;
  logic         gie, vec_req;
  logic [1:0]   vec_idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  grp_irq_agg #(.NUM_GROUPS(G), .SRC_PER_GRP(S)) i_grp_irq_agg (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .src_flag_set(src_flag_set),
    .src_flag_clr(src_flag_clr), .src_en_we(src_en_we), .src_en_wdata(src_en_wdata),
    .grp_flag_set(grp_flag_set), .grp_flag_clr(grp_flag_clr), .grp_en_we(grp_en_we),
    .grp_en_wdata(grp_en_wdata), .gie_set(gie_set), .gie_clr(gie_clr),
    .stack_full(stack_full), .vec_ack(vec_ack), .src_flag(src_flag), .src_en(src_en),
    .grp_flag(grp_flag), .grp_en(grp_en), .gie(gie), .vec_req(vec_req), .vec_idx(vec_idx)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    src_evt = '0; src_flag_set = '0; src_flag_clr = '0; src_en_we = 0; src_en_wdata = '0;
    grp_flag_set = '0; grp_flag_clr = '0; grp_en_we = 0; grp_en_wdata = '0;
    gie_set = 0; gie_clr = 0; vec_ack = 0;
  endtask

  // inputs held for one rising edge, then released at the next falling edge
  task automatic cyc();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic wipe();
    src_flag_clr = '1; gie_clr = 1; cyc();
    grp_flag_clr = '1; cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; stack_full = 0; idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 src_flag", src_flag, 0); check("R1 src_en", src_en, 0);
    check("R1 grp_flag", grp_flag, 0); check("R1 grp_en", grp_en, 0);
    check("R1 gie", gie, 0); check("R1 vec_req", vec_req, 0);

    // R2 / R4: each source with enables off, then persistence and clear
    for (int i = 0; i < N; i++) begin
      src_evt[i] = 1; cyc();
      check("R2 set by event", src_flag, 1 << i);
      cyc();
      check("R2 holds", src_flag, 1 << i);
      check("R4 disabled source no group", grp_flag, 0);
      src_flag_clr[i] = 1; cyc();
      check("R2 cleared", src_flag, 0);
      src_flag_set[i] = 1; cyc();
      check("R2 software set", src_flag, 1 << i);
      src_evt[i] = 1; src_flag_clr[i] = 1; cyc();
      check("R3 set wins over clear", src_flag, 1 << i);
      src_flag_clr[i] = 1; cyc();
    end

    // R4: mapping of each enabled source to its group
    src_en_we = 1; src_en_wdata = '1; cyc();
    for (int i = 0; i < N; i++) begin
      src_evt[i] = 1; cyc();
      check("R4 not yet", grp_flag, 0);
      cyc();
      check("R4 group set", grp_flag, 1 << (i / S));
      check("R5 no req without gie", vec_req, 0);
      grp_flag_clr = '1; cyc();
      check("R10 source condition beats clear", grp_flag, 1 << (i / S));
      wipe();
      check("R10 group cleared", grp_flag, 0);
    end
    src_en_we = 1; src_en_wdata = '0; cyc();

    // R5 / R6: sweep group flags, group enables, stack full
    for (int gf = 0; gf < 16; gf++) begin
      for (int ge = 0; ge < 16; ge++) begin
        for (int sf = 0; sf < 2; sf++) begin
          logic [3:0] e;
          int expi;
          grp_flag_clr = ~gf[3:0]; grp_flag_set = gf[3:0];
          grp_en_we = 1; grp_en_wdata = ge[3:0]; gie_set = 1;
          stack_full = sf[0];
          cyc();
          check("R10 set/clear mix", grp_flag, gf);
          e = (sf == 0) ? (gf[3:0] & ge[3:0]) : 4'b0;
          expi = 0;
          for (int k = 3; k >= 0; k--) if (e[k]) expi = k;
          check("R5 vec_req", vec_req, (e != 0));
          if (e != 0) check("R6 vec_idx", vec_idx, expi);
        end
      end
    end
    stack_full = 0;
    grp_flag_set = 4'b1111; gie_clr = 1; cyc();
    check("R5 gie off blocks", vec_req, 0);

    // R7: ack sequence
    grp_flag_clr = 4'b1001; grp_flag_set = 4'b0110; gie_set = 1; cyc();
    check("R6 idx before ack", vec_idx, 1);
    vec_ack = 1; gie_set = 1; grp_flag_set = 4'b0010; cyc();
    check("R7 group flag cleared", grp_flag, 4'b0100);
    check("R7 gie cleared", gie, 0);
    check("R7 req dropped", vec_req, 0);
    gie_set = 1; cyc();
    check("R9 req again", vec_req, 1); check("R9 next idx", vec_idx, 2);
    vec_ack = 1; cyc();
    check("R7 second ack", grp_flag, 0);
    wipe();

    // R8 / R9: serviced group with live source
    src_en_we = 1; src_en_wdata = 8'b0000_1000; cyc();
    src_evt[3] = 1; gie_set = 1; cyc(); cyc();
    check("R4 group1 set", grp_flag, 4'b0010);
    check("R6 idx group1", vec_idx, 1);
    vec_ack = 1; cyc();
    check("R8 source kept", src_flag, 8'b0000_1000);
    check("R7 group cleared on ack", grp_flag, 0);
    check("R7 gie after ack", gie, 0);
    cyc();
    check("R9 group re-raised", grp_flag, 4'b0010);
    check("R9 no req while gie off", vec_req, 0);
    gie_set = 1; cyc();
    check("R9 req after gie", vec_req, 1);
    check("R9 idx", vec_idx, 1);
    vec_ack = 1; src_flag_clr[3] = 1; cyc(); cyc();
    check("R9 stays clear once source cleared", grp_flag, 0);
    check("R8 cleared by software", src_flag, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule